// File: doc/BRIEF.md
# Strip Sample Reorder Buffer

This block performs a corner turn for a silicon strip detector built from four front-end inputs of 128 channels each, which together give 512 strips. Each front end delivers six time samples per event. The samples arrive time-sample by time-sample, with all four inputs side by side in one beat. Each beat carries a channel index, a sample index and four 9-bit words, one per input. Each word is an 8-bit amplitude with a hit marker in the top bit. The block stores a whole event and then replays it strip by strip. For every strip it emits the six samples back to back, so a later stage can fit the pulse shape of each strip from a contiguous run of words.

Storage is split into one 128 x 9 memory per input per sample, which is 24 memories per event. There are two such banks, used alternately. One event can be written into a free bank while the previous event is replayed from the other. The output strip number is formed as input index times 128 plus channel. Its upper two bits therefore pick which input's memories are read, and its lower seven bits address the word inside them. A full replay takes 512 x 6 consecutive cycles.

Top module: `strip_reorder_buf`

## Requirements
- R1: While and just after reset, out_valid, out_sos, out_eoe and ovf are low.
- R2: An event is replayed in strip-major order on consecutive words. Strip 0 to 511 each carries samples 0 to 5 in increasing order. out_strip bits 8:7 give the input index and bits 6:0 give the channel index.
- R3: A beat that arrives while the bank it would fill still holds an unreplayed event is dropped without changing any stored data. ovf is high in the following cycle, once for each dropped beat.
- R4: Each output word equals the 9-bit word written for that input, sample and channel. Bit 8 carries the hit marker and bits 7:0 carry the amplitude.
- R5: Nothing of an event is output until all 768 beats of the event (128 channels x 6 samples, each beat covering all 4 inputs, each written once) have been accepted.
- R6: The beats of one event may arrive in any order of channel and sample.
- R7: A new event may be written while the previous one is replayed. Events are replayed in the order they were completed, and this produces no ovf.
- R8: out_sos is high exactly on sample 0 of each strip. out_eoe is high exactly on sample 5 of strip 511.
- R9: Once an event's replay starts, out_valid stays high for 3072 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_chan | input | 7 | Channel index 0..127 of the beat |
| in_smp | input | 3 | Time sample index 0..5 of the beat |
| in_data | input | 36 | Four 9-bit words; input k occupies bits 9k+8:9k |
| out_valid | output | 1 | Output word present |
| out_data | output | 9 | Sample word: bit 8 hit marker, bits 7:0 amplitude |
| out_strip | output | 9 | Strip number 0..511 |
| out_smp | output | 3 | Sample index 0..5 within the strip |
| out_sos | output | 1 | First sample of a strip |
| out_eoe | output | 1 | Last word of the event |
| ovf | output | 1 | One-cycle pulse per dropped input beat |

## Verification
The bound checker watches the shape of the output stream on every cycle. Samples must step by one inside a strip, and strips must step by one at sample 5. Markers may sit only on their proper positions, a replay may not break off before its end marker, and any ovf pulse must follow a valid input beat. The scenarios alone can show that the data in each slot is the word written for that input, sample and channel. The same holds for the order-free filling of a bank, the hold-back of an incomplete event, the replay order of two buffered events, and the fact that dropped beats leave no trace in later events.

// File: rtl/strip_reorder_pkg.sv
package strip_reorder_pkg;

   typedef enum logic {
      RD_IDLE = 1'b0,
      RD_RUN  = 1'b1
   } rd_state_e;

endpackage

// File: rtl/strip_reorder_mem.sv
module strip_reorder_mem #(
   parameter int DEPTH = 128,
   parameter int DW    = 9,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   logic [DW-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[waddr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= store[raddr];
   end

endmodule

// File: rtl/strip_reorder_bank.sv
module strip_reorder_bank #(
   parameter int WORDS = 768,
   localparam int WC_W = $clog2(WORDS + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_fire,
   input  logic       rd_done,
   output logic       wr_ok,
   output logic       wbank,
   output logic       rbank,
   output logic [1:0] full,
   output logic       ovf
);

   localparam logic [WC_W-1:0] LAST_WORD = WC_W'(WORDS - 1);

   logic [WC_W-1:0] wcnt;
   logic            accept;
   logic            bank_done;
   logic [1:0]      full_nxt;

   assign wr_ok     = ~full[wbank];
   assign accept    = wr_fire & wr_ok;
   assign bank_done = accept && (wcnt == LAST_WORD);

   always_comb begin
      full_nxt = full;
      if (bank_done) full_nxt[wbank] = 1'b1;
      if (rd_done)   full_nxt[rbank] = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wcnt  <= '0;
         wbank <= 1'b0;
         rbank <= 1'b0;
         full  <= '0;
         ovf   <= 1'b0;
      end else begin
         full <= full_nxt;
         ovf  <= wr_fire & ~wr_ok;
         if (accept) begin
            if (bank_done) begin
               wcnt  <= '0;
               wbank <= ~wbank;
            end else begin
               wcnt <= wcnt + 1'b1;
            end
         end
         if (rd_done) rbank <= ~rbank;
      end
   end

endmodule

// File: rtl/strip_reorder_rdseq.sv
module strip_reorder_rdseq
   import strip_reorder_pkg::*;
#(
   parameter int N_STRIP = 512,
   parameter int N_SMP   = 6,
   localparam int ST_W   = $clog2(N_STRIP),
   localparam int SM_W   = $clog2(N_SMP)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            avail,
   output logic            rd_en,
   output logic [ST_W-1:0] rd_strip,
   output logic [SM_W-1:0] rd_smp,
   output logic            rd_done
);

   localparam logic [ST_W-1:0] LAST_ST = ST_W'(N_STRIP - 1);
   localparam logic [SM_W-1:0] LAST_SM = SM_W'(N_SMP - 1);

   rd_state_e state;

   assign rd_en   = (state == RD_RUN);
   assign rd_done = rd_en && (rd_strip == LAST_ST) && (rd_smp == LAST_SM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RD_IDLE;
         rd_strip <= '0;
         rd_smp   <= '0;
      end else begin
         case (state)
            RD_IDLE: begin
               rd_strip <= '0;
               rd_smp   <= '0;
               if (avail) state <= RD_RUN;
            end
            RD_RUN: begin
               if (rd_smp == LAST_SM) begin
                  rd_smp <= '0;
                  if (rd_strip == LAST_ST) begin
                     state    <= RD_IDLE;
                     rd_strip <= '0;
                  end else begin
                     rd_strip <= rd_strip + 1'b1;
                  end
               end else begin
                  rd_smp <= rd_smp + 1'b1;
               end
            end
            default: state <= RD_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/strip_reorder_buf.sv
module strip_reorder_buf
   import strip_reorder_pkg::*;
#(
   parameter int N_IN   = 4,
   parameter int N_CH   = 128,
   parameter int N_SMP  = 6,
   parameter int DW     = 9,
   localparam int CH_W  = $clog2(N_CH),
   localparam int IN_W  = $clog2(N_IN),
   localparam int ST_W  = CH_W + IN_W,
   localparam int SM_W  = $clog2(N_SMP)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [CH_W-1:0]      in_chan,
   input  logic [SM_W-1:0]      in_smp,
   input  logic [N_IN*DW-1:0]   in_data,
   output logic                 out_valid,
   output logic [DW-1:0]        out_data,
   output logic [ST_W-1:0]      out_strip,
   output logic [SM_W-1:0]      out_smp,
   output logic                 out_sos,
   output logic                 out_eoe,
   output logic                 ovf
);

   localparam int N_BANK = 2;
   localparam int WORDS  = N_CH * N_SMP;

   if (N_CH != (1 << CH_W)) begin : g_bad_ch
      $error("N_CH must be a power of two");
   end
   if (N_IN < 2 || N_IN != (1 << IN_W)) begin : g_bad_in
      $error("N_IN must be a power of two of at least 2");
   end
   if (N_SMP < 2) begin : g_bad_smp
      $error("N_SMP must be at least 2");
   end

   logic            wr_ok, wbank, rbank, rd_en, rd_done, sel_bank;
   logic [1:0]      full;
   logic [ST_W-1:0] rd_strip;
   logic [SM_W-1:0] rd_smp;
   logic [DW-1:0]   q [N_BANK][N_IN][N_SMP];

   strip_reorder_bank #(.WORDS(WORDS)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (in_valid),
      .rd_done (rd_done),
      .wr_ok   (wr_ok),
      .wbank   (wbank),
      .rbank   (rbank),
      .full    (full),
      .ovf     (ovf)
   );

   strip_reorder_rdseq #(.N_STRIP(N_IN * N_CH), .N_SMP(N_SMP)) u_rdseq (
      .clk      (clk),
      .rst_n    (rst_n),
      .avail    (full[rbank]),
      .rd_en    (rd_en),
      .rd_strip (rd_strip),
      .rd_smp   (rd_smp),
      .rd_done  (rd_done)
   );

   for (genvar b = 0; b < N_BANK; b++) begin : g_bank
      for (genvar i = 0; i < N_IN; i++) begin : g_in
         for (genvar s = 0; s < N_SMP; s++) begin : g_smp
            logic we_l;
            logic re_l;
            assign we_l = in_valid & wr_ok & (wbank == 1'(b)) & (in_smp == SM_W'(s));
            assign re_l = rd_en & (rbank == 1'(b));
            strip_reorder_mem #(.DEPTH(N_CH), .DW(DW)) u_mem (
               .clk   (clk),
               .we    (we_l),
               .waddr (in_chan),
               .wdata (in_data[i*DW +: DW]),
               .re    (re_l),
               .raddr (rd_strip[CH_W-1:0]),
               .rdata (q[b][i][s])
            );
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_strip <= '0;
         out_smp   <= '0;
         out_sos   <= 1'b0;
         out_eoe   <= 1'b0;
         sel_bank  <= 1'b0;
      end else begin
         out_valid <= rd_en;
         out_strip <= rd_strip;
         out_smp   <= rd_smp;
         out_sos   <= rd_en && (rd_smp == '0);
         out_eoe   <= rd_done;
         sel_bank  <= rbank;
      end
   end

   always_comb begin
      out_data = '0;
      for (int b = 0; b < N_BANK; b++) begin
         for (int i = 0; i < N_IN; i++) begin
            for (int s = 0; s < N_SMP; s++) begin
               if (sel_bank == 1'(b) && out_strip[ST_W-1:CH_W] == IN_W'(i) &&
                   out_smp == SM_W'(s))
                  out_data = q[b][i][s];
            end
         end
      end
   end

endmodule

// File: rtl/strip_reorder_chk.sv
module strip_reorder_chk #(
   parameter int N_STRIP = 512,
   parameter int N_SMP   = 6,
   localparam int ST_W   = $clog2(N_STRIP),
   localparam int SM_W   = $clog2(N_SMP)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            out_valid,
   input logic [ST_W-1:0] out_strip,
   input logic [SM_W-1:0] out_smp,
   input logic            out_sos,
   input logic            out_eoe,
   input logic            ovf
);

   localparam logic [ST_W-1:0] LAST_ST = ST_W'(N_STRIP - 1);
   localparam logic [SM_W-1:0] LAST_SM = SM_W'(N_SMP - 1);

   // R8: start marker only on sample 0
   p_sos_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_sos |-> out_smp == '0);

   // R8: end marker only on the final slot of the event
   p_eoe_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_eoe |-> out_strip == LAST_ST && out_smp == LAST_SM);

   // R2: samples step by one inside a strip
   p_smp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_smp != LAST_SM |=>
         out_valid && out_smp == $past(out_smp) + SM_W'(1) && $stable(out_strip));

   // R2: strip advances after its last sample
   p_strip_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_smp == LAST_SM && !out_eoe |=>
         out_valid && out_smp == '0 && out_strip == $past(out_strip) + ST_W'(1));

   // R9: replay does not stop before its end marker
   p_burst_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_eoe |=> out_valid);

   // R3: an overflow pulse is caused by an input beat
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |-> $past(in_valid));

endmodule

bind strip_reorder_buf strip_reorder_chk #(
   .N_STRIP (N_IN * N_CH),
   .N_SMP   (N_SMP)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_strip (out_strip),
   .out_smp   (out_smp),
   .out_sos   (out_sos),
   .out_eoe   (out_eoe),
   .ovf       (ovf)
);

// File: tb/strip_reorder_buf_tb.sv
module strip_reorder_buf_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int N_IN  = 4;
   localparam int N_CH  = 128;
   localparam int N_SMP = 6;
   localparam int EV_WORDS = N_IN * N_CH * N_SMP;
   localparam int WATCHDOG = 190000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [6:0]  in_chan = '0;
   logic [2:0]  in_smp = '0;
   logic [35:0] in_data = '0;
   logic        out_valid, out_sos, out_eoe, ovf;
   logic [8:0]  out_data, out_strip;
   logic [2:0]  out_smp;

   int checks = 0;
   int errors = 0;
   int exp_ev[$];
   int pos = 0;
   int words_seen = 0;
   int evs_done = 0;
   int ovf_cnt = 0;
   int cycles = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   strip_reorder_buf dut_i (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_chan (in_chan),
      .in_smp (in_smp), .in_data (in_data), .out_valid (out_valid),
      .out_data (out_data), .out_strip (out_strip), .out_smp (out_smp),
      .out_sos (out_sos), .out_eoe (out_eoe), .ovf (ovf)
   );

   function automatic logic [8:0] word_of(int ev, int inp, int s, int ch);
      logic [7:0] amp;
      logic       hit;
      amp = 8'((ev * 37 + inp * 53 + s * 11 + ch * 3) & 255);
      hit = ((ch + s + ev + inp) % 5) == 0;
      return {hit, amp};
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // output monitor, sampled away from the active edge
   always @(negedge clk) begin
      cycles++;
      if (ovf) ovf_cnt++;
      if (out_valid) begin
         words_seen++;
         if (exp_ev.size() == 0) begin
            check(0, "R7 word with no pending event", 1, 0);
         end else begin
            automatic int ev = exp_ev[0];
            automatic int st = pos / N_SMP;
            automatic int sm = pos % N_SMP;
            automatic logic [8:0] w = word_of(ev, st / N_CH, sm, st % N_CH);
            check(out_data == w, "R4 data", int'(out_data), int'(w));
            check(out_strip == 9'(st) && out_smp == 3'(sm), "R2 strip/sample",
                  int'(out_strip) * 8 + int'(out_smp), st * 8 + sm);
            check(out_sos == (sm == 0) && out_eoe == (st == 511 && sm == 5),
                  "R8 markers", int'({out_sos, out_eoe}),
                  int'({(sm == 0), (st == 511 && sm == 5)}));
            pos++;
            if (pos == EV_WORDS / N_IN * N_IN) begin
               pos = 0;
               void'(exp_ev.pop_front());
               evs_done++;
            end
         end
      end else if (pos != 0) begin
         check(0, "R9 gap inside replay", pos, 0);
      end
      if (cycles > WATCHDOG) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual %0d expected %0d", cycles, WATCHDOG);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic send_beat(int ev, int s, int ch);
      in_valid = 1'b1;
      in_chan  = 7'(ch);
      in_smp   = 3'(s);
      for (int i = 0; i < N_IN; i++) in_data[i*9 +: 9] = word_of(ev, i, s, ch);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // order 0: natural; 1: reversed samples and channels
   task automatic send_event(int ev, int order, int n_beats);
      int k = 0;
      for (int s0 = 0; s0 < N_SMP; s0++) begin
         for (int c0 = 0; c0 < N_CH; c0++) begin
            if (k < n_beats) begin
               if (order == 0) send_beat(ev, s0, c0);
               else send_beat(ev, N_SMP - 1 - s0, N_CH - 1 - c0);
            end
            k++;
         end
      end
   endtask

   task automatic wait_done(int target);
      while (evs_done < target) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check(!out_valid && !out_sos && !out_eoe && !ovf, "R1 outputs in reset",
            int'({out_valid, out_sos, out_eoe, ovf}), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(!out_valid && !out_sos && !out_eoe && !ovf, "R1 outputs after reset",
            int'({out_valid, out_sos, out_eoe, ovf}), 0);
   endtask

   task automatic t_single;
      int e0 = errors;
      exp_ev.push_back(1);
      send_event(1, 0, N_CH * N_SMP);
      wait_done(1);
      check(errors == e0, "R2 single event replay", errors - e0, 0);
   endtask

   task automatic t_reverse;
      int e0 = errors;
      exp_ev.push_back(2);
      send_event(2, 1, N_CH * N_SMP);
      wait_done(2);
      check(errors == e0, "R6 reversed write order", errors - e0, 0);
   endtask

   task automatic t_hold;
      int w0 = words_seen;
      exp_ev.push_back(3);
      send_event(3, 0, N_CH * N_SMP - 1);
      repeat (60) @(negedge clk);
      check(words_seen == w0 && !out_valid, "R5 incomplete event held",
            words_seen - w0, 0);
      send_beat(3, N_SMP - 1, N_CH - 1);
      wait_done(3);
      check(words_seen - w0 == 3072, "R9 words in event", words_seen - w0, 3072);
   endtask

   task automatic t_back_to_back;
      int e0 = errors;
      int o0 = ovf_cnt;
      exp_ev.push_back(4);
      exp_ev.push_back(5);
      send_event(4, 0, N_CH * N_SMP);
      send_event(5, 1, N_CH * N_SMP);
      check(evs_done == 3 && exp_ev.size() == 2, "R7 second event written during replay",
            evs_done, 3);
      wait_done(5);
      check(errors == e0, "R7 order of two buffered events", errors - e0, 0);
      check(ovf_cnt == o0, "R7 no overflow", ovf_cnt - o0, 0);
   endtask

   task automatic t_overflow;
      int o0 = ovf_cnt;
      int e0 = errors;
      exp_ev.push_back(6);
      exp_ev.push_back(7);
      send_event(6, 0, N_CH * N_SMP);
      send_event(7, 0, N_CH * N_SMP);
      send_event(12, 1, 100);
      @(negedge clk);
      check(ovf_cnt - o0 == 100, "R3 overflow pulses", ovf_cnt - o0, 100);
      wait_done(6);
      exp_ev.push_back(8);
      send_event(8, 0, N_CH * N_SMP);
      wait_done(8);
      check(errors == e0, "R3 dropped beats left no data", errors - e0, 0);
      check(ovf_cnt - o0 == 100, "R3 no further overflow", ovf_cnt - o0, 100);
   endtask

   initial begin
      t_reset();
      t_single();
      t_reverse();
      t_hold();
      t_back_to_back();
      t_overflow();
      repeat (20) @(negedge clk);
      check(exp_ev.size() == 0 && !out_valid, "R7 all events replayed",
            exp_ev.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule